// File: doc/BRIEF.md
# Three-channel ADC conversion sequencer

This block controls an external analog-to-digital converter on behalf of three independently enabled voltage channels. It divides the system clock by a programmable factor to produce an ADC clock. Once software sets the run bit, the block services the eligible channels in turn. For each one it drives that channel's programmed input code onto the select output and waits a programmable number of ADC clocks so the input can settle. It then pulses a start strobe and waits for the converter's done strobe. The 8-bit result is stored left-aligned in the channel's 10-bit buffer, and the channel's sticky event bit is set.

Software reaches the block through a small synchronous register port. Writes take effect at the clock edge, and reads are combinational from the address. After reset the block is configured for its slowest operation: the divider and the settling delay are at their maximum values, and every channel, interrupt and input selection is off. The result buffers keep their contents through reset.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, the register contents are as follows.
  - Address 0 (control) reads 0. Its fields are: bit 0 run, bits 3:1 channel enables with bit 1 for channel 1, and bits 6:4 interrupt enables with bit 4 for channel 1.
  - Address 1 (divider) reads 63.
  - Address 2 (settling delay) reads 255.
  - Address 3 (events) reads 0.
  - Addresses 4, 5 and 6 (input codes of channels 1 to 3) read 31.
  - On the outputs, irq is 0, adc_sel is 31 and conv_start is 0.
- R2: A divider write stores the value of bits 5:0, with any value below 4 stored as 4. A divider write is ignored while the run bit is 1.
- R3: A channel's conv_start pulse follows its selection by exactly delay × divider + 1 cycles. From the edge at which a conv_done is accepted to the next conv_start, the interval is delay × divider + 2 cycles.
- R4: conv_start is a one-cycle pulse. During settling and conversion, adc_sel carries the serviced channel's input code. When no channel is being serviced, adc_sel is 31.
- R5: While running, channels are serviced in the repeating order 1, 2, 3. The sequence starts at channel 1 every time the run bit is set. Any channel that is disabled or whose input code is 31 is skipped. When no channel is eligible, no conversion starts.
- R6: A conv_done received during a conversion stores {conv_result, 2'b00} in that channel's buffer and sets the channel's event bit (bit 0 for channel 1). The buffers for channels 1 to 3 are read at addresses 8, 9 and 10.
- R7: irq is 1 exactly when some event bit and its interrupt enable are both 1. Writing 1 to an event bit clears it, and writing 0 leaves it unchanged.
- R8: Clearing the run bit during settling or conversion aborts the work in progress. No later conv_start follows, and no buffer or event bit changes. A conv_done that arrives while no conversion is in progress is ignored.
- R9: A reset leaves the buffer contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| adc_sel | output | 5 | Input code presented to the converter |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_done | input | 1 | Conversion complete strobe |
| conv_result | input | 8 | Conversion value, valid with conv_done |
| irq | output | 1 | Masked OR of the channel event bits |

## Verification
The bench builds the block with its default parameters: three channels, a 6-bit divider and an 8-bit delay. It sweeps the divider over 4, 5, 6 and 9 and the delay over 0 to 3, and at each point checks the exact settling interval, the service order and the buffer contents. One run at the reset defaults exercises the full 63 × 255 interval, and the sub-minimum divider writes exercise the clamp. The small channel count brings every skip pattern within reach, as well as both abort windows and a reset that leaves the buffers intact.

// File: rtl/adc_conv_seq_pkg.sv
package adc_conv_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_CONV   = 2'd2
  } seq_state_e;

  // Raise a divider value to the smallest legal factor.
  function automatic int clamp_div(input int raw, input int lo);
    clamp_div = (raw < lo) ? lo : raw;
  endfunction

  // Next eligible channel after "last", circularly; -1 when none.
  function automatic int rr_pick(input logic [7:0] elig, input int last, input int n);
    int idx;
    rr_pick = -1;
    for (int k = n; k >= 1; k--) begin
      idx = (last + k) % n;
      if (elig[idx]) rr_pick = idx;
    end
  endfunction

  // Settling length in system clocks.
  function automatic int settle_cycles(input int dly, input int div);
    settle_cycles = dly * div + 1;
  endfunction

endpackage

// File: rtl/adc_conv_seq_regs.sv
module adc_conv_seq_regs
  import adc_conv_seq_pkg::*;
#(
  parameter int NCH     = 3,
  parameter int DIV_W   = 6,
  parameter int DIV_MIN = 4,
  parameter int DLY_W   = 8,
  parameter int SEL_W   = 5,
  parameter int RES_W   = 10,
  parameter int AW      = 4,
  parameter int DW      = 16,
  localparam int IDX_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  input  logic                       cap_fire,
  input  logic [IDX_W-1:0]           cap_idx,
  input  logic [NCH-1:0][RES_W-1:0]  bufs,
  output logic                       run_q,
  output logic [NCH-1:0]             chen_q,
  output logic [NCH-1:0]             ie_q,
  output logic [NCH-1:0]             evt_q,
  output logic [DIV_W-1:0]           div_q,
  output logic [DLY_W-1:0]           dly_q,
  output logic [NCH-1:0][SEL_W-1:0]  sel_q,
  output logic [DW-1:0]              rdata
);

  localparam logic [AW-1:0] A_CTL = AW'(0);
  localparam logic [AW-1:0] A_DIV = AW'(1);
  localparam logic [AW-1:0] A_DLY = AW'(2);
  localparam logic [AW-1:0] A_EVT = AW'(3);
  localparam int            A_SEL = 4;
  localparam int            A_BUF = 8;

  logic [NCH-1:0] evt_set;
  logic [NCH-1:0] evt_clr;
  logic           wdata_unused;

  assign wdata_unused = ^wdata[DW-1:2*NCH+1];
  assign evt_set = cap_fire ? (NCH'(1) << cap_idx) : '0;
  assign evt_clr = (we && addr == A_EVT) ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      chen_q <= '0;
      ie_q   <= '0;
      evt_q  <= '0;
      div_q  <= '1;
      dly_q  <= '1;
      for (int i = 0; i < NCH; i++) sel_q[i] <= '1;
    end else begin
      if (we && addr == A_CTL) begin
        run_q  <= wdata[0];
        chen_q <= wdata[NCH:1];
        ie_q   <= wdata[2*NCH:NCH+1];
      end
      if (we && addr == A_DIV && !run_q)
        div_q <= DIV_W'(clamp_div(int'(wdata[DIV_W-1:0]), DIV_MIN));
      if (we && addr == A_DLY)
        dly_q <= wdata[DLY_W-1:0];
      for (int i = 0; i < NCH; i++)
        if (we && addr == AW'(A_SEL + i)) sel_q[i] <= wdata[SEL_W-1:0];
      evt_q <= (evt_q & ~evt_clr) | evt_set;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTL) rdata = DW'({ie_q, chen_q, run_q});
    if (addr == A_DIV) rdata = DW'(div_q);
    if (addr == A_DLY) rdata = DW'(dly_q);
    if (addr == A_EVT) rdata = DW'(evt_q);
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(A_SEL + i)) rdata = DW'(sel_q[i]);
      if (addr == AW'(A_BUF + i)) rdata = DW'(bufs[i]);
    end
  end

endmodule

// File: rtl/adc_conv_seq_clkdiv.sv
module adc_conv_seq_clkdiv #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = !clr && (cnt_q == div - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/adc_conv_seq_fsm.sv
module adc_conv_seq_fsm
  import adc_conv_seq_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int DLY_W  = 8,
  parameter int SEL_W  = 5,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic [NCH-1:0]            elig,
  input  logic [NCH-1:0][SEL_W-1:0] sel,
  input  logic [DLY_W-1:0]          dly,
  input  logic                      tick,
  input  logic                      conv_done,
  output logic                      div_clr,
  output logic                      conv_start,
  output logic [SEL_W-1:0]          adc_sel,
  output logic                      conv_busy,
  output logic                      settle_done,
  output logic                      cap_fire,
  output logic [IDX_W-1:0]          cap_idx
);

  seq_state_e       state_q;
  logic [IDX_W-1:0] cur_q;
  logic [IDX_W-1:0] last_q;
  logic [DLY_W-1:0] dcnt_q;
  logic [7:0]       elig8;
  int               pick;
  logic [IDX_W-1:0] pick_idx;

  always_comb begin
    elig8 = '0;
    elig8[NCH-1:0] = elig;
    pick = rr_pick(elig8, int'(last_q), NCH);
  end

  assign pick_idx    = pick[IDX_W-1:0];
  assign settle_done = run && state_q == SQ_SETTLE && dcnt_q >= dly;
  assign cap_fire    = run && state_q == SQ_CONV && conv_done;
  assign cap_idx     = cur_q;
  assign conv_busy   = run && state_q == SQ_CONV;
  assign div_clr     = !(run && state_q == SQ_SETTLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      cur_q      <= '0;
      last_q     <= IDX_W'(NCH - 1);
      dcnt_q     <= '0;
      conv_start <= 1'b0;
      adc_sel    <= '1;
    end else begin
      conv_start <= 1'b0;
      if (!run) begin
        state_q <= SQ_IDLE;
        last_q  <= IDX_W'(NCH - 1);
        dcnt_q  <= '0;
        adc_sel <= '1;
      end else begin
        case (state_q)
          SQ_IDLE: begin
            if (pick >= 0) begin
              cur_q   <= pick_idx;
              adc_sel <= sel[pick_idx];
              dcnt_q  <= '0;
              state_q <= SQ_SETTLE;
            end
          end
          SQ_SETTLE: begin
            if (settle_done) begin
              conv_start <= 1'b1;
              state_q    <= SQ_CONV;
            end else if (tick) begin
              dcnt_q <= dcnt_q + 1'b1;
            end
          end
          SQ_CONV: begin
            if (conv_done) begin
              last_q  <= cur_q;
              adc_sel <= '1;
              state_q <= SQ_IDLE;
            end
          end
          default: state_q <= SQ_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/adc_conv_seq_bufs.sv
module adc_conv_seq_bufs #(
  parameter int NCH    = 3,
  parameter int CONV_W = 8,
  parameter int RES_W  = 10,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PAD_W = RES_W - CONV_W
) (
  input  logic                      clk,
  input  logic                      cap_fire,
  input  logic [IDX_W-1:0]          cap_idx,
  input  logic [CONV_W-1:0]         conv_result,
  output logic [NCH-1:0][RES_W-1:0] bufs
);

  // No reset: contents survive reset and are undefined before first use.
  for (genvar g = 0; g < NCH; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (cap_fire && cap_idx == IDX_W'(g))
        bufs[g] <= {conv_result, {PAD_W{1'b0}}};
    end
  end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int NCH     = 3,
  parameter int DIV_W   = 6,
  parameter int DIV_MIN = 4,
  parameter int DLY_W   = 8,
  parameter int SEL_W   = 5,
  parameter int CONV_W  = 8,
  parameter int RES_W   = 10,
  parameter int AW      = 4,
  parameter int DW      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [SEL_W-1:0]  adc_sel,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [CONV_W-1:0] conv_result,
  output logic              irq
);

  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic                      run_q;
  logic [NCH-1:0]            chen_q;
  logic [NCH-1:0]            ie_q;
  logic [NCH-1:0]            evt_q;
  logic [DIV_W-1:0]          div_q;
  logic [DLY_W-1:0]          dly_q;
  logic [NCH-1:0][SEL_W-1:0] sel_q;
  logic [NCH-1:0][RES_W-1:0] bufs;
  logic [NCH-1:0]            elig;
  logic                      tick;
  logic                      div_clr;
  logic                      conv_busy;
  logic                      settle_done;
  logic                      cap_fire;
  logic [IDX_W-1:0]          cap_idx;

  for (genvar g = 0; g < NCH; g++) begin : g_elig
    assign elig[g] = chen_q[g] && (sel_q[g] != '1);
  end

  assign irq = |(evt_q & ie_q);

  adc_conv_seq_regs #(
    .NCH(NCH), .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DLY_W(DLY_W),
    .SEL_W(SEL_W), .RES_W(RES_W), .AW(AW), .DW(DW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .cap_fire(cap_fire), .cap_idx(cap_idx), .bufs(bufs),
    .run_q(run_q), .chen_q(chen_q), .ie_q(ie_q), .evt_q(evt_q),
    .div_q(div_q), .dly_q(dly_q), .sel_q(sel_q), .rdata(bus_rdata)
  );

  adc_conv_seq_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(div_clr), .div(div_q), .tick(tick)
  );

  adc_conv_seq_fsm #(.NCH(NCH), .DLY_W(DLY_W), .SEL_W(SEL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .run(run_q), .elig(elig), .sel(sel_q),
    .dly(dly_q), .tick(tick), .conv_done(conv_done), .div_clr(div_clr),
    .conv_start(conv_start), .adc_sel(adc_sel), .conv_busy(conv_busy),
    .settle_done(settle_done), .cap_fire(cap_fire), .cap_idx(cap_idx)
  );

  adc_conv_seq_bufs #(.NCH(NCH), .CONV_W(CONV_W), .RES_W(RES_W)) u_bufs (
    .clk(clk), .cap_fire(cap_fire), .cap_idx(cap_idx),
    .conv_result(conv_result), .bufs(bufs)
  );

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int NCH   = 3,
  parameter int DIV_W = 6,
  parameter int SEL_W = 5,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic [DIV_W-1:0] div_q,
  input logic [NCH-1:0]   evt_q,
  input logic             cap_fire,
  input logic [IDX_W-1:0] cap_idx,
  input logic             conv_busy,
  input logic             conv_start,
  input logic [SEL_W-1:0] adc_sel
);

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R8
  no_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !conv_start);

  // R4
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy && $past(conv_busy) |-> $stable(adc_sel));

  // R2
  div_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && $past(run_q) |-> $stable(div_q));

  // R6
  event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> evt_q[$past(cap_idx)]);

  // R4
  start_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> adc_sel != '1);

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.NCH(NCH), .DIV_W(DIV_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .div_q(div_q), .evt_q(evt_q),
  .cap_fire(cap_fire), .cap_idx(cap_idx), .conv_busy(conv_busy),
  .conv_start(conv_start), .adc_sel(adc_sel)
);

// File: tb/adc_conv_seq_bench.sv
module adc_conv_seq_bench;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [4:0]  adc_sel;
  logic        conv_start;
  logic        conv_done = 1'b0;
  logic [7:0]  conv_result = '0;
  logic        irq;

  always #5 clk = ~clk;

  adc_conv_seq u_adc_conv_seq (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_sel(adc_sel),
    .conv_start(conv_start), .conv_done(conv_done),
    .conv_result(conv_result), .irq(irq)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Converter model
  int       n_start = 0, n_done = 0, mdl_cnt = 0, dbl = 0;
  bit       mute = 0, inject = 0, prev_start = 0;
  logic [4:0] st_sel [64];
  int       st_cyc [64];
  int       dn_cyc [64];

  function automatic logic [7:0] mk_res(input logic [4:0] s);
    mk_res = {s, s[2:0]} ^ 8'h5A;
  endfunction

  always @(negedge clk) begin
    conv_done = 1'b0;
    if (prev_start && conv_start) dbl++;
    prev_start = conv_start;
    if (inject) begin
      conv_done   = 1'b1;
      conv_result = 8'hA5;
      inject      = 0;
    end else if (conv_start) begin
      if (n_start < 64) begin
        st_sel[n_start] = adc_sel;
        st_cyc[n_start] = cyc;
      end
      n_start++;
      mdl_cnt = LAT;
    end else if (mdl_cnt > 0) begin
      mdl_cnt--;
      if (mdl_cnt == 0 && !mute) begin
        conv_done   = 1'b1;
        conv_result = mk_res(adc_sel);
        if (n_done < 64) dn_cyc[n_done] = cyc + 1;
        n_done++;
      end
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_addr = 4'(a);
    #1 d = int'(bus_rdata);
  endtask

  task automatic clr_log();
    @(posedge clk);
    n_start = 0; n_done = 0; mdl_cnt = 0;
  endtask

  task automatic wait_done(input int n, input int limit);
    for (int i = 0; i < limit && n_done < n; i++) @(negedge clk);
  endtask

  task automatic wait_starts(input int n, input int limit);
    for (int i = 0; i < limit && n_start < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  int v;
  int old_buf [3];
  int divs [4] = '{4, 5, 6, 9};
  int sels [3] = '{3, 12, 20};

  initial begin
    do_reset();
    // R1 reset state
    rd(0, v); chk("R1", "control", v, 0);
    rd(1, v); chk("R1", "divider", v, 63);
    rd(2, v); chk("R1", "delay", v, 255);
    rd(3, v); chk("R1", "events", v, 0);
    for (int i = 0; i < 3; i++) begin rd(4 + i, v); chk("R1", "input code", v, 31); end
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "adc_sel", int'(adc_sel), 31);
    chk("R1", "conv_start", int'(conv_start), 0);

    // R2 divider clamp
    for (int w = 0; w < 8; w++) begin
      wr(1, w); rd(1, v); chk("R2", "divider clamp", v, (w < 4) ? 4 : w);
    end

    // R3 at reset-default slow settings
    wr(1, 63); wr(2, 255); wr(4, 5);
    clr_log();
    wr(0, 16'h0003);
    wait_starts(1, 20000);
    wr(1, 5); rd(1, v); chk("R2", "divider write while running", v, 63);
    wait_starts(2, 20000);
    chk("R3", "slow gap", st_cyc[1] - dn_cyc[0], 255 * 63 + 2);
    chk("R4", "slow sel", int'(st_sel[0]), 5);
    wr(0, 0);

    // R3 R5 R6 sweep
    wr(4, sels[0]); wr(5, sels[1]); wr(6, sels[2]);
    for (int a = 0; a < 4; a++) begin
      for (int d = 0; d < 4; d++) begin
        wr(0, 0); wr(1, divs[a]); wr(2, d); wr(3, 7);
        clr_log();
        wr(0, 16'h007F);
        wait_done(4, 3000);
        wr(0, 16'h0070);
        for (int k = 0; k < 4; k++)
          chk("R5", "service order", int'(st_sel[k]), sels[k % 3]);
        for (int k = 0; k < 3; k++)
          chk("R3", "settle gap", st_cyc[k + 1] - dn_cyc[k], d * divs[a] + 2);
        for (int i = 0; i < 3; i++) begin
          rd(8 + i, v);
          chk("R6", "buffer", v, int'({mk_res(5'(sels[i])), 2'b00}));
        end
      end
    end

    // R7 events and interrupt
    rd(3, v); chk("R7", "events after sweep", v, 7);
    chk("R7", "irq all enabled", int'(irq), 1);
    wr(0, 0); chk("R7", "irq masked", int'(irq), 0);
    wr(3, 1); rd(3, v); chk("R7", "w1c bit0", v, 6);
    wr(0, 16'h0010); chk("R7", "irq ch1 only", int'(irq), 0);
    wr(0, 16'h0020); chk("R7", "irq ch2 only", int'(irq), 1);
    wr(3, 0); rd(3, v); chk("R7", "write zero keeps", v, 6);
    wr(3, 7); rd(3, v); chk("R7", "w1c all", v, 0);
    chk("R7", "irq after clear", int'(irq), 0);

    // R5 skip by reserved code
    wr(0, 0); wr(1, 4); wr(2, 1); wr(5, 31);
    clr_log();
    wr(0, 16'h000F);
    wait_done(4, 3000);
    wr(0, 0);
    for (int k = 0; k < 4; k++)
      chk("R5", "skip reserved", int'(st_sel[k]), (k % 2 == 0) ? 3 : 20);

    // R5 skip by disable, restart from channel 1
    wr(5, 12);
    clr_log();
    wr(0, 16'h000D);
    wait_done(3, 3000);
    wr(0, 0);
    for (int k = 0; k < 3; k++)
      chk("R5", "skip disabled", int'(st_sel[k]), (k % 2 == 0) ? 12 : 20);

    // R5 nothing eligible
    wr(5, 31);
    clr_log();
    wr(0, 16'h0005);
    repeat (300) @(negedge clk);
    chk("R5", "no eligible starts", n_start, 0);
    chk("R4", "idle sel", int'(adc_sel), 31);
    wr(0, 0);

    // R8 abort during conversion
    wr(3, 7);
    for (int i = 0; i < 3; i++) begin rd(8 + i, v); old_buf[i] = v; end
    wr(4, 9);
    mute = 1;
    clr_log();
    wr(0, 16'h0003);
    wait_starts(1, 3000);
    wr(0, 0);
    mute = 0;
    @(posedge clk); inject = 1;
    repeat (100) @(negedge clk);
    rd(3, v); chk("R8", "events after abort", v, 0);
    rd(8, v); chk("R8", "buffer after abort", v, old_buf[0]);
    chk("R8", "starts after abort", n_start, 1);
    chk("R4", "sel after abort", int'(adc_sel), 31);

    // R8 abort during settling
    wr(1, 9); wr(2, 200);
    clr_log();
    wr(0, 16'h0003);
    repeat (50) @(negedge clk);
    wr(0, 0);
    repeat (2000) @(negedge clk);
    chk("R8", "starts after settle abort", n_start, 0);
    rd(3, v); chk("R8", "events after settle abort", v, 0);

    // R9 buffers survive reset
    do_reset();
    for (int i = 0; i < 3; i++) begin
      rd(8 + i, v); chk("R9", "buffer through reset", v, old_buf[i]);
    end
    rd(4, v); chk("R1", "code after second reset", v, 31);

    chk("R4", "double-width start pulses", dbl, 0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule